// File: doc/BRIEF.md
# Multicycle AES-128 Encryption Engine

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. It does not process a round per clock. A single 128-bit state register is reused for every transform, and a controller steps the transforms one at a time, allowing each one its own latency. The byte substitution reads a synchronous table that takes two cycles. The row rotation and the column mixing each take one cycle. The round key comes from a separate key-expansion unit, which the controller starts and then waits on.

The user holds `load` high with the plaintext and key on the inputs. On every edge where `load` is high, the state takes plaintext XOR key and the key unit takes the key. The rounds start after `load` falls. When the tenth round ends, `done` rises and the ciphertext is valid on `cipherText`. Both stay as they are until the next `load`. Asserting `load` at any time drops the work in progress and starts over.

Bytes follow the usual AES column-major order. Bits [127:120] of each 128-bit port hold byte 0, which is the first byte of the block, and bits [7:0] hold byte 15.

Top module: `aesCipherCore`

## Requirements
- R1: For any plaintext and key, the value on `cipherText` while `done` is high equals the AES-128 encryption of that plaintext under that key. Byte 0 sits in bits [127:120]. Rounds 1 to 9 apply substitution, row rotation, column mixing and key addition, and round 10 leaves out the column mixing.
- R2: Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives ciphertext 3925841d02dc09fbdc118597196a0b32.
- R3: Count rising edges from the first edge at which `load` is sampled low, with that edge as edge 1. `done` stays low through edge 79 and is high after edge 80.
- R4: After any rising edge at which `load` is sampled high, `done` is low, whatever the block was doing before.
- R5: Once `done` is high, `done` and `cipherText` keep their values on every edge until `load` is sampled high again.
- R6: Changes to `plainText` and `cipherKey` while `load` is low do not affect the result, during an encryption or after it.
- R7: If `load` is raised while an encryption is running, that encryption is dropped. The block then encrypts the new inputs with the full R3 latency, counted from the new fall of `load`.
- R8: While `rstN` is low, `done` is low and `cipherText` is zero.
- R9: When `load` is held high for several cycles, the block uses the inputs present at the last edge with `load` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | High: capture inputs and hold the block ready; falling: start encryption |
| plainText | input | 128 | Block to encrypt, byte 0 in bits [127:120] |
| cipherKey | input | 128 | Cipher key, byte 0 in bits [127:120] |
| cipherText | output | 128 | Encrypted block, valid while `done` is high |
| done | output | 1 | High when the encryption has finished, until the next `load` |

## Verification
Two functions can fall on the same edge: a new `load`, and the controller's own round progress, whether that is a key addition completing on the key unit's done pulse or the final round ending. The bench raises `load` partway through a running encryption and also right after a finished one. It then judges that `done` drops at once, that the full latency restarts from the new fall, and that the new ciphertext matches the reference model. Random vectors, some of them with the inputs scrambled while `load` is low, are checked against a reference model written in the bench that uses its own field-inverse S-box.

// File: rtl/aesPkg.sv
package aesPkg;
  localparam int BLOCK_BITS  = 128;
  localparam int NUM_BYTES   = BLOCK_BITS / 8;
  localparam int NUM_ROUNDS  = 10;
  localparam int ROUND_W     = $clog2(NUM_ROUNDS + 1);
  localparam int SUB_CYC     = 2;
  localparam int KEY_CYC     = 4;
  localparam int FULL_ROUND  = SUB_CYC + 1 + 1 + KEY_CYC;
  localparam int LAST_ROUND  = SUB_CYC + 1 + KEY_CYC;
  localparam int ENC_LATENCY = 1 + (NUM_ROUNDS - 1) * FULL_ROUND + LAST_ROUND;

  typedef logic [BLOCK_BITS-1:0] block_t;
  typedef logic [7:0] sboxTable_t [256];

  typedef struct packed {
    logic loadState;
    logic subWrite;
    logic shiftWrite;
    logic mixWrite;
    logic addWrite;
  } dpStrobe_t;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // Walks the multiplicative group with generator 3 and its inverse in step.
  function automatic sboxTable_t buildSbox();
    sboxTable_t t;
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    for (int i = 0; i < 256; i++) t[i] = 8'h00;
    t[0] = 8'h63;
    for (int i = 0; i < 255; i++) begin
      p = p ^ xtime(p);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      t[p] = x ^ 8'h63;
    end
    return t;
  endfunction

  function automatic block_t shiftRows(input block_t s);
    block_t r;
    for (int c = 0; c < 4; c++)
      for (int rw = 0; rw < 4; rw++)
        r[BLOCK_BITS-1-8*(4*c+rw) -: 8] = s[BLOCK_BITS-1-8*(4*((c+rw)%4)+rw) -: 8];
    return r;
  endfunction

  function automatic block_t mixColumns(input block_t s);
    block_t r;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[BLOCK_BITS-1-8*(4*c)   -: 8];
      a1 = s[BLOCK_BITS-1-8*(4*c+1) -: 8];
      a2 = s[BLOCK_BITS-1-8*(4*c+2) -: 8];
      a3 = s[BLOCK_BITS-1-8*(4*c+3) -: 8];
      r[BLOCK_BITS-1-8*(4*c)   -: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
      r[BLOCK_BITS-1-8*(4*c+1) -: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
      r[BLOCK_BITS-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
      r[BLOCK_BITS-1-8*(4*c+3) -: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end
    return r;
  endfunction
endpackage

// File: rtl/aesKeyUnit.sv
module aesKeyUnit
  import aesPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   load,
  input  block_t cipherKey,
  input  logic   start,
  output block_t roundKey,
  output logic   keyDone
);
  localparam sboxTable_t SBOX = buildSbox();

  typedef enum logic [1:0] {K_IDLE, K_LOOK, K_APPLY, K_FIN} kState_t;

  kState_t    kState;
  logic [7:0] rcon;
  logic [31:0] rotWord, subWord, temp, w0n, w1n, w2n, w3n;

  assign rotWord = {roundKey[23:0], roundKey[31:24]};

  // Registered table read, one byte per lane.
  for (genvar g = 0; g < 4; g++) begin : gSubLane
    always_ff @(posedge clk) subWord[8*g +: 8] <= SBOX[rotWord[8*g +: 8]];
  end

  assign temp = subWord ^ {rcon, 24'h0};
  assign w0n  = roundKey[127:96] ^ temp;
  assign w1n  = roundKey[95:64]  ^ w0n;
  assign w2n  = roundKey[63:32]  ^ w1n;
  assign w3n  = roundKey[31:0]   ^ w2n;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kState   <= K_IDLE;
      roundKey <= '0;
      rcon     <= 8'h01;
    end else if (load) begin
      kState   <= K_IDLE;
      roundKey <= cipherKey;
      rcon     <= 8'h01;
    end else begin
      case (kState)
        K_IDLE:  if (start) kState <= K_LOOK;
        K_LOOK:  kState <= K_APPLY;
        K_APPLY: begin
          roundKey <= {w0n, w1n, w2n, w3n};
          rcon     <= xtime(rcon);
          kState   <= K_FIN;
        end
        default: kState <= K_IDLE;
      endcase
    end
  end

  assign keyDone = (kState == K_FIN);
endmodule

// File: rtl/aesCtrl.sv
module aesCtrl
  import aesPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      load,
  input  logic      keyDone,
  output dpStrobe_t strobe,
  output logic      keyStart,
  output logic      done
);
  typedef enum logic [3:0] {
    C_IDLE, C_LOAD, C_SUBA, C_SUBB, C_SHIFT, C_MIX, C_KSTART, C_KWAIT, C_DONE
  } cState_t;

  cState_t              cState;
  logic [ROUND_W-1:0]   round;
  logic                 lastRound;

  assign lastRound = (round == ROUND_W'(NUM_ROUNDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cState <= C_IDLE;
      round  <= '0;
    end else if (load) begin
      cState <= C_LOAD;
      round  <= '0;
    end else begin
      case (cState)
        C_LOAD: begin
          cState <= C_SUBA;
          round  <= ROUND_W'(1);
        end
        C_SUBA:   cState <= C_SUBB;
        C_SUBB:   cState <= C_SHIFT;
        C_SHIFT:  cState <= lastRound ? C_KSTART : C_MIX;
        C_MIX:    cState <= C_KSTART;
        C_KSTART: cState <= C_KWAIT;
        C_KWAIT: if (keyDone) begin
          if (lastRound) cState <= C_DONE;
          else begin
            cState <= C_SUBA;
            round  <= round + 1'b1;
          end
        end
        default: cState <= cState;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadState  = load;
    strobe.subWrite   = !load && (cState == C_SUBB);
    strobe.shiftWrite = !load && (cState == C_SHIFT);
    strobe.mixWrite   = !load && (cState == C_MIX);
    strobe.addWrite   = !load && (cState == C_KWAIT) && keyDone;
  end

  assign keyStart = !load && (cState == C_KSTART);
  assign done     = (cState == C_DONE);
endmodule

// File: rtl/aesDatapath.sv
module aesDatapath
  import aesPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  block_t    plainText,
  input  block_t    cipherKey,
  input  block_t    roundKey,
  output block_t    stateQ
);
  localparam sboxTable_t SBOX = buildSbox();

  block_t subQ;

  // One registered table read per state byte, free running.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : gSubByte
    always_ff @(posedge clk) subQ[8*g +: 8] <= SBOX[stateQ[8*g +: 8]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  stateQ <= '0;
    else if (strobe.loadState)  stateQ <= plainText ^ cipherKey;
    else if (strobe.subWrite)   stateQ <= subQ;
    else if (strobe.shiftWrite) stateQ <= shiftRows(stateQ);
    else if (strobe.mixWrite)   stateQ <= mixColumns(stateQ);
    else if (strobe.addWrite)   stateQ <= stateQ ^ roundKey;
  end
endmodule

// File: rtl/aesCipherCore.sv
module aesCipherCore
  import aesPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic [BLOCK_BITS-1:0] plainText,
  input  logic [BLOCK_BITS-1:0] cipherKey,
  output logic [BLOCK_BITS-1:0] cipherText,
  output logic                  done
);
  dpStrobe_t strobe;
  logic      keyStart, keyDone;
  block_t    roundKey;

  aesCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .load(load), .keyDone(keyDone),
    .strobe(strobe), .keyStart(keyStart), .done(done)
  );

  aesKeyUnit key_i (
    .clk(clk), .rstN(rstN), .load(load), .cipherKey(cipherKey),
    .start(keyStart), .roundKey(roundKey), .keyDone(keyDone)
  );

  aesDatapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .plainText(plainText),
    .cipherKey(cipherKey), .roundKey(roundKey), .stateQ(cipherText)
  );
endmodule

// File: rtl/aesCipherCore_chk.sv
module aesCipherCore_chk
  import aesPkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   load,
  input logic   done,
  input block_t cipherText,
  input logic   keyStart,
  input logic   keyDone
);
  logic [7:0] sinceLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceLoad <= '0;
    else if (load)             sinceLoad <= '0;
    else if (sinceLoad != 8'hff) sinceLoad <= sinceLoad + 8'd1;
  end

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    load |=> !done);                                              // R4
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !load) |=> done);                                    // R5
  AST_CT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !load) |=> $stable(cipherText));                     // R5
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (sinceLoad == 8'(ENC_LATENCY)));              // R3
  AST_DONE_AFTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(keyDone));                              // R3
  AST_KEY_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    keyStart |-> !keyDone);                                       // R3
endmodule

bind aesCipherCore aesCipherCore_chk chk_i (
  .clk(clk), .rstN(rstN), .load(load), .done(done),
  .cipherText(cipherText), .keyStart(keyStart), .keyDone(keyDone)
);

// File: tb/aesCipherCore_tb_top.sv
module aesCipherCore_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 80;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic [127:0] plainText = '0;
  logic [127:0] cipherKey = '0;
  logic [127:0] cipherText;
  logic         done;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aesCipherCore dut_i (
    .clk(clk), .rstN(rstN), .load(load), .plainText(plainText),
    .cipherKey(cipherKey), .cipherText(cipherText), .done(done)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] gMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] refSub(input logic [7:0] a);
    logic [7:0] inv = 8'h01;
    logic [7:0] p = a;
    for (int k = 1; k < 8; k++) begin
      p   = gMul(p, p);
      inv = gMul(inv, p);
    end
    if (a == 8'h00) inv = 8'h00;
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] refEncrypt(input logic [127:0] pt, input logic [127:0] key);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] k [16];
    logic [7:0] tmp [4];
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      k[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = refSub(s[i]);
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++) s[4*c+rw] = t[4*((c+rw)%4)+rw];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = gMul(a0,8'h02) ^ gMul(a1,8'h03) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ gMul(a1,8'h02) ^ gMul(a2,8'h03) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ gMul(a2,8'h02) ^ gMul(a3,8'h03);
          s[4*c+3] = gMul(a0,8'h03) ^ a1 ^ a2 ^ gMul(a3,8'h02);
        end
      end
      tmp[0] = refSub(k[13]) ^ rc;
      tmp[1] = refSub(k[14]);
      tmp[2] = refSub(k[15]);
      tmp[3] = refSub(k[12]);
      for (int i = 0; i < 4; i++)  k[i] = k[i] ^ tmp[i];
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      rc = gMul(rc, 8'h02);
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drives load for 'hold' cycles; only the last cycle carries pt/key.
  task automatic startRun(input logic [127:0] pt, input logic [127:0] key, input int hold);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      load      = 1'b1;
      plainText = (h == hold - 1) ? pt  : rnd128();
      cipherKey = (h == hold - 1) ? key : rnd128();
    end
    @(negedge clk);
    check(done == 1'b0, "R4", "done after load edge", {127'd0, done}, 128'd0);
    load = 1'b0;
  endtask

  task automatic waitResult(input logic [127:0] exp, input bit scramble, input string req);
    bit early = 1'b0;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (scramble && (k == 5 || k == 60)) begin
        plainText = rnd128();
        cipherKey = rnd128();
      end
      if (k < LAT && done) early = 1'b1;
    end
    check(!early, "R3", "done before latency", {127'd0, early}, 128'd0);
    check(done == 1'b1, "R3", "done at latency", {127'd0, done}, 128'd1);
    check(cipherText == exp, req, "ciphertext", cipherText, exp);
  endtask

  task automatic holdCheck(input int cycles);
    logic [127:0] snap = cipherText;
    bit bad = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      plainText = rnd128();
      cipherKey = rnd128();
      if (!done || cipherText != snap) bad = 1'b1;
    end
    check(!bad, "R5", "hold after done", cipherText, snap);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [127:0] pt, key, stdKey, stdPt;
    void'($urandom(32'd20240607));
    stdKey = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    stdPt  = 128'h3243f6a8885a308d313198a2e0370734;

    // R8: reset values
    plainText = rnd128();
    cipherKey = rnd128();
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8", "done in reset", {127'd0, done}, 128'd0);
    check(cipherText == '0, "R8", "ciphertext in reset", cipherText, 128'd0);
    rstN = 1'b1;

    // R2: standard vector, then hold and ignored-input check (R5, R6)
    startRun(stdPt, stdKey, 1);
    waitResult(128'h3925841d02dc09fbdc118597196a0b32, 1'b0, "R2");
    check(refEncrypt(stdPt, stdKey) == 128'h3925841d02dc09fbdc118597196a0b32,
          "R2", "bench model", refEncrypt(stdPt, stdKey), 128'h3925841d02dc09fbdc118597196a0b32);
    holdCheck(12);

    // R1: all-zero corner and all-ones corner
    startRun('0, '0, 1);
    waitResult(refEncrypt('0, '0), 1'b0, "R1");
    startRun('1, '1, 1);
    waitResult(refEncrypt('1, '1), 1'b0, "R1");

    // R1/R6: random vectors, half with inputs scrambled while load is low
    for (int n = 0; n < 16; n++) begin
      pt  = rnd128();
      key = rnd128();
      startRun(pt, key, 1);
      waitResult(refEncrypt(pt, key), n[0], n[0] ? "R6" : "R1");
    end

    // R9: long load, last sampled values win
    pt  = rnd128();
    key = rnd128();
    startRun(pt, key, 4);
    waitResult(refEncrypt(pt, key), 1'b0, "R9");

    // R7: reload in the middle of a run
    startRun(rnd128(), rnd128(), 1);
    repeat (37) @(negedge clk);
    check(done == 1'b0, "R7", "busy before reload", {127'd0, done}, 128'd0);
    pt  = rnd128();
    key = rnd128();
    startRun(pt, key, 1);
    waitResult(refEncrypt(pt, key), 1'b1, "R7");

    // R7: reload on the edge right after completion, same values
    startRun(pt, key, 1);
    waitResult(refEncrypt(pt, key), 1'b0, "R7");
    holdCheck(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule